// File: doc/BRIEF.md
# Micro Translation Cache

This block is a small, fully associative cache of recently used translations, held in flops. It sits in front of a larger joint translation buffer. A lookup presents a virtual page number and an 8-bit address-space identifier. In the same cycle the block answers with a hit flag, the cached physical frame and the page flags. One instance with 8 entries serves data accesses, and a second instance with 4 entries serves instruction fetches. The entry count is a parameter.

On a miss the block raises a fill request that carries the missing page and identifier. It holds that request until the joint buffer returns the entry with a one-cycle valid pulse. The block then places the entry in a free slot if there is one, and otherwise in the slot named by a round-robin pointer.

Two strobes empty the whole cache: the joint buffer's normal write command and a dedicated invalidate strobe. The non-invalidating write command leaves the cache alone. A translation that the joint buffer has evicted therefore stays usable here until one of the two clearing strobes arrives. This lets the higher associativity of this cache hide the low associativity of the backing buffer.

Top module: `utlb_cache`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `fillReq` is low.
- R2: On a hit, `hitPfn` and `hitFlags` equal the frame and flags stored in the matching entry.
- R3: The lookup is combinational. `hit`, `hitPfn` and `hitFlags` reflect the lookup inputs in the same cycle. `hit` is low whenever `lookupValid` is low.
- R4: An entry matches when it is valid and its page number equals `lookupVpn`. Its identifier must also equal `lookupAsid`, unless the entry was filled with the global bit set, in which case any identifier matches.
- R5: A fill is written into the lowest-numbered invalid entry. If all entries are valid, it is written into the entry named by a round-robin pointer. The pointer is 0 after reset, is not changed by clears, and advances by one (wrapping from N-1 to 0) on each fill that evicts an entry.
- R6: A `jtlbWriteNi` strobe has no effect on the cache contents.
- R7: A `jtlbWrite` strobe invalidates all entries; lookups in the following cycles miss.
- R8: A `utlbInval` strobe invalidates all entries; lookups in the following cycles miss.
- R9: When a clearing strobe coincides with `fillValid`, the cache ends up empty, the filled entry included, and the fill request still retires.
- R10: A valid lookup that misses while no request is outstanding raises `fillReq` in the next cycle. `fillReqVpn` and `fillReqAsid` are latched from that lookup. `fillReq` stays high until `fillValid` and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupAsid | input | ASID_W | Address-space identifier of the access |
| hit | output | 1 | Lookup matched a valid entry |
| hitPfn | output | PFN_W | Physical frame of the matching entry |
| hitFlags | output | FLAG_W | Page flags of the matching entry |
| fillReq | output | 1 | Outstanding request to the joint buffer |
| fillReqVpn | output | VPN_W | Page number of the outstanding request |
| fillReqAsid | output | ASID_W | Identifier of the outstanding request |
| fillValid | input | 1 | One-cycle pulse: fill data present |
| fillVpn | input | VPN_W | Page number of the returned entry |
| fillAsid | input | ASID_W | Identifier of the returned entry |
| fillGlobal | input | 1 | Returned entry matches any identifier |
| fillPfn | input | PFN_W | Physical frame of the returned entry |
| fillFlags | input | FLAG_W | Page flags of the returned entry |
| jtlbWrite | input | 1 | Joint-buffer write command (clears cache) |
| jtlbWriteNi | input | 1 | Joint-buffer write without cache clear |
| utlbInval | input | 1 | Explicit cache invalidate strobe |

## Verification
The hardest state to reach is a full cache in which the round-robin pointer, not the free-slot search, picks the victim. Getting there also means telling which entry was evicted using only lookups. The stimulus fills every slot through complete miss-and-fill handshakes, then adds more fills. After each fill it sweeps a grid of page numbers and identifiers, so the one missing translation shows which slot was replaced. The same sweeps follow each strobe, including a clear that lands in the same cycle as a fill. That case is reached by holding a request open and pulsing the invalidate together with the fill data.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  // Strobes from the control block to the entry store.
  typedef struct packed {
    logic fillWe;    // write the returned entry into the selected slot
    logic clearAll;  // drop every entry; wins over fillWe
  } utlb_strobe_t;
endpackage

// File: rtl/utlb_ctrl.sv
module utlb_ctrl
  import utlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [ASID_W-1:0] lookupAsid,
  input  logic              lookupHit,
  input  logic [N-1:0]      validVec,
  input  logic              fillValid,
  input  logic              jtlbWrite,
  input  logic              jtlbWriteNi,
  input  logic              utlbInval,
  output logic              fillReq,
  output logic [VPN_W-1:0]  fillReqVpn,
  output logic [ASID_W-1:0] fillReqAsid,
  output utlb_strobe_t      strobe,
  output logic [N-1:0]      fillSel
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             reqPending;
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] victimIdx;
  logic             freeFound;

  // Clearing strobes win over a fill arriving in the same cycle.
  always_comb begin
    strobe.clearAll = jtlbWrite | utlbInval;
    strobe.fillWe   = reqPending & fillValid & ~strobe.clearAll;
  end

  // Lowest-numbered free slot.
  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
    end
    victimIdx = freeFound ? freeIdx : rrPtr;
  end

  for (genvar g = 0; g < N; g++) begin : g_sel
    assign fillSel[g] = strobe.fillWe && (victimIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrPtr <= '0;
    end else if (strobe.fillWe && !freeFound) begin
      rrPtr <= (rrPtr == IDX_W'(N - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqPending  <= 1'b0;
      fillReqVpn  <= '0;
      fillReqAsid <= '0;
    end else if (reqPending) begin
      if (fillValid) reqPending <= 1'b0;
    end else if (lookupValid && !lookupHit) begin
      reqPending  <= 1'b1;
      fillReqVpn  <= lookupVpn;
      fillReqAsid <= lookupAsid;
    end
  end

  assign fillReq = reqPending;

  // R10: request held until the fill pulse
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqPending && !fillValid) |=> reqPending);
  // R10: request retires after the fill pulse
  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqPending && fillValid) |=> !reqPending);
  // R6: non-clearing write leaves the valid set untouched
  p_ni_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (jtlbWriteNi && !jtlbWrite && !utlbInval && !fillValid) |=> $stable(validVec));
  // R5: a fill into a cache with a free slot grows the valid set by one
  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fillWe && !(&validVec)) |=>
      ($countones(validVec) == $past($countones(validVec)) + 1));
endmodule

// File: rtl/utlb_datapath.sv
module utlb_datapath
  import utlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  utlb_strobe_t      strobe,
  input  logic [N-1:0]      fillSel,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [FLAG_W-1:0] fillFlags,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [ASID_W-1:0] lookupAsid,
  output logic              lookupHit,
  output logic [PFN_W-1:0]  hitPfn,
  output logic [FLAG_W-1:0] hitFlags,
  output logic [N-1:0]      validVec
);
  logic [VPN_W-1:0]  entVpn  [N];
  logic [ASID_W-1:0] entAsid [N];
  logic              entGlb  [N];
  logic [PFN_W-1:0]  entPfn  [N];
  logic [FLAG_W-1:0] entFlg  [N];
  logic [N-1:0]      hitVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0;
    end else if (strobe.clearAll) begin
      validVec <= '0;
    end else begin
      validVec <= validVec | fillSel;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (fillSel[g]) begin
        entVpn[g]  <= fillVpn;
        entAsid[g] <= fillAsid;
        entGlb[g]  <= fillGlobal;
        entPfn[g]  <= fillPfn;
        entFlg[g]  <= fillFlags;
      end
    end
    assign hitVec[g] = validVec[g] && (entVpn[g] == lookupVpn) &&
                       (entGlb[g] || (entAsid[g] == lookupAsid));
  end

  always_comb begin
    hitPfn   = '0;
    hitFlags = '0;
    for (int i = 0; i < N; i++) begin
      if (hitVec[i]) begin
        hitPfn   = hitPfn | entPfn[i];
        hitFlags = hitFlags | entFlg[i];
      end
    end
    lookupHit = lookupValid && (|hitVec);
  end

  // R4: at most one entry matches a lookup
  p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitVec));
  // R7: a clearing strobe empties the store
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (validVec == '0));
  // R5: the selected slot is valid after a fill
  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fillWe && !strobe.clearAll) |=> ((validVec & $past(fillSel)) == $past(fillSel)));
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
  import utlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [ASID_W-1:0] lookupAsid,
  output logic              hit,
  output logic [PFN_W-1:0]  hitPfn,
  output logic [FLAG_W-1:0] hitFlags,
  output logic              fillReq,
  output logic [VPN_W-1:0]  fillReqVpn,
  output logic [ASID_W-1:0] fillReqAsid,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic              fillGlobal,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic [FLAG_W-1:0] fillFlags,
  input  logic              jtlbWrite,
  input  logic              jtlbWriteNi,
  input  logic              utlbInval
);
  utlb_strobe_t strobe;
  logic [N-1:0] fillSel;
  logic [N-1:0] validVec;

  utlb_ctrl #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupAsid(lookupAsid),
    .lookupHit(hit), .validVec(validVec), .fillValid(fillValid),
    .jtlbWrite(jtlbWrite), .jtlbWriteNi(jtlbWriteNi), .utlbInval(utlbInval),
    .fillReq(fillReq), .fillReqVpn(fillReqVpn), .fillReqAsid(fillReqAsid),
    .strobe(strobe), .fillSel(fillSel)
  );

  utlb_datapath #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .FLAG_W(FLAG_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fillSel(fillSel),
    .fillVpn(fillVpn), .fillAsid(fillAsid), .fillGlobal(fillGlobal),
    .fillPfn(fillPfn), .fillFlags(fillFlags),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupAsid(lookupAsid),
    .lookupHit(hit), .hitPfn(hitPfn), .hitFlags(hitFlags), .validVec(validVec)
  );
endmodule

// File: tb/utlb_cache_tb_top.sv
module utlb_cache_tb_top;
  localparam int N = 8, VPN_W = 20, ASID_W = 8, PFN_W = 20, FLAG_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lookupValid = 0, fillValid = 0, fillGlobal = 0;
  logic jtlbWrite = 0, jtlbWriteNi = 0, utlbInval = 0;
  logic [VPN_W-1:0] lookupVpn = '0, fillVpn = '0;
  logic [ASID_W-1:0] lookupAsid = '0, fillAsid = '0;
  logic [PFN_W-1:0] fillPfn = '0;
  logic [FLAG_W-1:0] fillFlags = '0;
  logic hit, fillReq;
  logic [PFN_W-1:0] hitPfn;
  logic [FLAG_W-1:0] hitFlags;
  logic [VPN_W-1:0] fillReqVpn;
  logic [ASID_W-1:0] fillReqAsid;

  always #5 clk = ~clk;

  utlb_cache #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .FLAG_W(FLAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .lookupAsid(lookupAsid), .hit(hit), .hitPfn(hitPfn), .hitFlags(hitFlags),
    .fillReq(fillReq), .fillReqVpn(fillReqVpn), .fillReqAsid(fillReqAsid),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid),
    .fillGlobal(fillGlobal), .fillPfn(fillPfn), .fillFlags(fillFlags),
    .jtlbWrite(jtlbWrite), .jtlbWriteNi(jtlbWriteNi), .utlbInval(utlbInval)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Reference model of the cache contents
  logic              mValid [N];
  logic [VPN_W-1:0]  mVpn   [N];
  logic [ASID_W-1:0] mAsid  [N];
  logic              mGlb   [N];
  logic [PFN_W-1:0]  mPfn   [N];
  logic [FLAG_W-1:0] mFlg   [N];
  int                mRr = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
  endtask

  task automatic modelFill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                           input logic g, input logic [PFN_W-1:0] p, input logic [FLAG_W-1:0] f);
    int idx = -1;
    for (int i = 0; i < N; i++) if (!mValid[i] && idx < 0) idx = i;
    if (idx < 0) begin
      idx = mRr;
      mRr = (mRr + 1) % N;
    end
    mValid[idx] = 1; mVpn[idx] = v; mAsid[idx] = a; mGlb[idx] = g; mPfn[idx] = p; mFlg[idx] = f;
  endtask

  // Lookup compared against the model in the same cycle (R3), then withdrawn before the edge
  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a, input string tag);
    logic eh = 0;
    logic [PFN_W-1:0] ep = '0;
    logic [FLAG_W-1:0] ef = '0;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == v && (mGlb[i] || mAsid[i] == a)) begin
        eh = 1; ep = mPfn[i]; ef = mFlg[i];
      end
    @(negedge clk);
    lookupValid = 1; lookupVpn = v; lookupAsid = a;
    #1;
    chk(hit == eh, {tag, " hit"}, hit, eh);
    if (eh) begin
      chk(hitPfn == ep, {tag, " pfn R2"}, hitPfn, ep);
      chk(hitFlags == ef, {tag, " flags R2"}, hitFlags, ef);
    end
    lookupValid = 0;
  endtask

  task automatic sweep(input string tag);
    for (int v = 'h100; v < 'h110; v++)
      for (int a = 0; a < 10; a++) look(VPN_W'(v), ASID_W'(a), tag);
    for (int v = 'h200; v < 'h204; v++) begin
      look(VPN_W'(v), 8'd1, tag);
      look(VPN_W'(v), 8'd255, tag);
    end
  endtask

  task automatic doFill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                        input logic g, input logic [PFN_W-1:0] p, input logic [FLAG_W-1:0] f,
                        input bit inval);
    @(negedge clk);
    lookupValid = 1; lookupVpn = v; lookupAsid = a;
    #1;
    chk(hit == 0 && fillReq == 0, "R10 precondition miss", {hit, fillReq}, 0);
    @(negedge clk);
    lookupValid = 0;
    chk(fillReq == 1, "R10 request raised", fillReq, 1);
    chk(fillReqVpn == v, "R10 request page", fillReqVpn, v);
    chk(fillReqAsid == a, "R10 request asid", fillReqAsid, a);
    repeat (2) @(negedge clk);
    chk(fillReq == 1, "R10 request held", fillReq, 1);
    fillValid = 1; fillVpn = v; fillAsid = a; fillGlobal = g; fillPfn = p; fillFlags = f;
    utlbInval = inval;
    @(negedge clk);
    fillValid = 0; utlbInval = 0;
    chk(fillReq == 0, inval ? "R9 request retired" : "R10 request retired", fillReq, 0);
    if (inval) modelClear(); else modelFill(v, a, g, p, f);
  endtask

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk); #1;
    chk(fillReq == 0, "R1 fillReq", fillReq, 0);
    chk(hit == 0, "R3 hit low when idle", hit, 0);
    sweep("R1 empty");

    // R2/R4/R5: fill every slot, one entry global
    for (int i = 0; i < N; i++)
      doFill(VPN_W'('h100 + i), ASID_W'(i + 1), (i == 3), PFN_W'('h5000 + i * 7), FLAG_W'(i), 0);
    sweep("R2 R4 full");
    for (int a = 0; a < 256; a++) begin
      look(VPN_W'('h103), ASID_W'(a), "R4 global any asid");
      look(VPN_W'('h105), ASID_W'(a), "R4 private asid");
    end

    // R5: round-robin eviction when full
    doFill(VPN_W'('h200), 8'd1, 0, PFN_W'('hA000), 4'hA, 0);
    sweep("R5 evict first");
    doFill(VPN_W'('h201), 8'd1, 0, PFN_W'('hA001), 4'hB, 0);
    sweep("R5 evict second");

    // R6: non-clearing write
    @(negedge clk); jtlbWriteNi = 1;
    @(negedge clk); jtlbWriteNi = 0;
    sweep("R6 ni keeps");

    // R7: normal write clears
    @(negedge clk); jtlbWrite = 1;
    @(negedge clk); jtlbWrite = 0;
    modelClear();
    sweep("R7 cleared");

    // R8: explicit invalidate clears
    for (int i = 0; i < 3; i++)
      doFill(VPN_W'('h108 + i), 8'd2, 0, PFN_W'('h7000 + i), FLAG_W'(i + 5), 0);
    sweep("R5 refill lowest free");
    @(negedge clk); utlbInval = 1;
    @(negedge clk); utlbInval = 0;
    modelClear();
    sweep("R8 cleared");

    // R9: invalidate coincides with fill
    doFill(VPN_W'('h10C), 8'd4, 0, PFN_W'('h1234), 4'h3, 0);
    doFill(VPN_W'('h10D), 8'd4, 0, PFN_W'('h1235), 4'h4, 1);
    sweep("R9 inval wins");
    doFill(VPN_W'('h10E), 8'd9, 1, PFN_W'('h4321), 4'h6, 0);
    sweep("R5 fill after clear");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule